// File: doc/BRIEF.md
# Fuse-Programmable Registered AND-OR Array

This block models a small field-programmable logic array: twenty array signals (twelve dedicated inputs, four register states fed back, and four bidirectional pin values) each offer a true and a complement literal to a plane of 64 product terms. A 2560-bit fuse map, shifted in serially after reset, decides which literals each product term includes. The product terms are grouped eight to a cell. Four cells OR their terms into D registers whose inverted value drives a three-state output pin under a shared active-low enable. The other four cells are combinational: seven terms form the output and the eighth is that cell's own three-state enable.

A preload mode lets a test sequence force each register to a chosen pin level on one clock, bypassing the next-state logic. Reset clears every register, so every registered pin reads high. Until the full map is loaded, every output is held disabled and the registers do not move. A disabled bidirectional cell acts as an extra input, because every pin value is fed back into the plane.

Top module: `pal_array_top`

## Requirements
- R1: While `cfg_done` is low, each clock with `cfg_shift` high stores `cfg_bit` as the next fuse in ascending index order, starting at fuse 0. Fuse index is 40*row + column. `cfg_done` rises at the clock edge that stores the 2560th bit.
- R2: Array signal s owns two columns: 2s carries its true value and 2s+1 its complement. Signals 0-11 are `din[11:0]`, 12-15 are register states 0-3, and 16-19 are `io_in[3:0]`.
- R3: A product term is the AND of the literals whose fuse is 1. A term that has both literals of one signal set is always 0. A term that has no fuse set is always 1.
- R4: Cell k owns rows 8k to 8k+7. Cells 2-5 are registers 0-3. Cells 0, 1, 6 and 7 are bidirectional cells 0, 1, 2 and 3.
- R5: When loaded and not preloading, a register takes the OR of its eight terms at the rising clock edge.
- R6: `q_out` is the bitwise inverse of the register states. `q_en` is high only when loaded, `oe_n` is low and `pre_mode` is low.
- R7: `io_out[j]` is the OR of the cell's rows 8k+1 to 8k+7. `io_oe[j]` is high only when loaded and row 8k is true.
- R8: Synchronous active-low reset clears all registers (pins read 4'hF) and the load progress. While unloaded, `q_en` and `io_oe` stay low and the registers hold.
- R9: With `pre_mode` high after loading, a clock edge sets every register to the inverse of `pre_lvl`, so each pin then reads the applied level. The array result is ignored.
- R10: Once `cfg_done` is high, further `cfg_shift` pulses change neither the fuse map nor `cfg_done`.
- R11: `io_in` of a disabled cell feeds the plane like any dedicated input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Array and configuration clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_shift | input | 1 | Shift one fuse bit this cycle |
| cfg_bit | input | 1 | Serial fuse data |
| cfg_done | output | 1 | Fuse map fully loaded |
| din | input | 12 | Dedicated array inputs |
| oe_n | input | 1 | Active-low enable of registered pins |
| pre_mode | input | 1 | Register preload mode |
| pre_lvl | input | 4 | Pin levels applied during preload |
| q_out | output | 4 | Registered pin values (inverted state) |
| q_en | output | 1 | Drive enable of registered pins |
| io_in | input | 4 | Pin values of the bidirectional cells |
| io_out | output | 4 | Combinational cell outputs |
| io_oe | output | 4 | Per-cell drive enables |

## Verification
The combinational results `io_out`, `io_oe` and `q_en` are due in the same cycle as their inputs. `q_out` moves one rising edge after the inputs that decide the next state, and `cfg_done` rises on the edge that takes the 2560th bit. The bench changes inputs on the falling edge and compares all outputs against its model one time step later, before the next rising edge. It then advances the model state at that rising edge, so that every comparison sees exactly one register stage. The loaded map builds an enabled 4-bit counter and four distinct I/O functions. These include an always-true enable, a never-true enable, and a cell that forwards a disabled pin.

// File: rtl/pal_pkg.sv
package pal_pkg;
    // Default geometry of the array.
    localparam int DIN_W  = 12;
    localparam int NREG_D = 4;
    localparam int NIO_D  = 4;
    localparam int TERMS_D = 8;
endpackage

// File: rtl/pal_fuse_loader.sv
// Serial fuse store. Bits arrive lowest index first; after FUSES shifts the
// map is frozen and done is set. Assumes reset before the first load.
module pal_fuse_loader #(
    parameter int FUSES = 2560
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             shift_en,
    input  logic             bit_in,
    output logic [FUSES-1:0] fuses,
    output logic             done
);
    localparam int CW = $clog2(FUSES + 1);

    logic [CW-1:0] cnt;

    assign done = (cnt == CW'(FUSES));

    // Count accepted bits until the map is full.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (shift_en && !done)
            cnt <= cnt + 1'b1;
    end

    // Shift from the top so the first bit lands at index 0.
    always_ff @(posedge clk) begin
        if (shift_en && !done)
            fuses <= {bit_in, fuses[FUSES-1:1]};
    end
endmodule

// File: rtl/pal_and_plane.sv
// AND plane: each row ANDs the literals whose fuse is 1. Column 2s is the
// true literal of signal s, column 2s+1 its complement.
module pal_and_plane #(
    parameter int NSIG = 20,
    parameter int ROWS = 64
) (
    input  logic [ROWS*2*NSIG-1:0] fuses,
    input  logic [NSIG-1:0]        sig,
    output logic [ROWS-1:0]        pt
);
    localparam int COLS = 2 * NSIG;

    logic [COLS-1:0] lit;

    for (genvar s = 0; s < NSIG; s++) begin : g_lit
        assign lit[2*s]     = sig[s];
        assign lit[2*s + 1] = ~sig[s];
    end

    for (genvar r = 0; r < ROWS; r++) begin : g_row
        // A blown fuse (0) forces its column true inside the AND.
        assign pt[r] = &(lit | ~fuses[r*COLS +: COLS]);
    end
endmodule

// File: rtl/pal_reg_cell.sv
// Registered cell: ORs its terms into a D flop. It holds until the map is
// loaded; preload stores the inverse of the applied pin level.
module pal_reg_cell #(
    parameter int TERMS = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             loaded,
    input  logic             pre_mode,
    input  logic             pre_lvl,
    input  logic [TERMS-1:0] terms,
    output logic             state
);
    // Clear, preload, or capture the sum of terms.
    always_ff @(posedge clk) begin
        if (!rst_n)
            state <= 1'b0;
        else if (loaded) begin
            if (pre_mode)
                state <= ~pre_lvl;
            else
                state <= |terms;
        end
    end
endmodule

// File: rtl/pal_io_cell.sv
// Combinational cell: term 0 is the drive enable, the remaining terms are
// ORed into the output. Purely combinational.
module pal_io_cell #(
    parameter int TERMS = 8
) (
    input  logic             loaded,
    input  logic [TERMS-1:0] terms,
    output logic             out,
    output logic             en
);
    assign out = |terms[TERMS-1:1];
    assign en  = loaded & terms[0];
endmodule

// File: rtl/pal_array_top.sv
// Programmable AND-OR array with registered and combinational cells.
// Registered cells sit in the middle of the cell order, split evenly by the
// combinational cells. Assumes a reset and a full fuse load before use.
module pal_array_top
    import pal_pkg::*;
#(
    parameter int NDIN  = DIN_W,
    parameter int NREG  = NREG_D,
    parameter int NIO   = NIO_D,
    parameter int TERMS = TERMS_D
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cfg_shift,
    input  logic            cfg_bit,
    output logic            cfg_done,
    input  logic [NDIN-1:0] din,
    input  logic            oe_n,
    input  logic            pre_mode,
    input  logic [NREG-1:0] pre_lvl,
    output logic [NREG-1:0] q_out,
    output logic            q_en,
    input  logic [NIO-1:0]  io_in,
    output logic [NIO-1:0]  io_out,
    output logic [NIO-1:0]  io_oe
);
    localparam int NSIG      = NDIN + NREG + NIO;
    localparam int COLS      = 2 * NSIG;
    localparam int CELLS     = NREG + NIO;
    localparam int ROWS      = CELLS * TERMS;
    localparam int FUSES     = ROWS * COLS;
    localparam int FIRST_REG = NIO / 2;

    logic [FUSES-1:0] fuses;
    logic [NREG-1:0]  state;
    logic [NSIG-1:0]  sig;
    logic [ROWS-1:0]  pt;

    assign sig = {io_in, state, din};

    pal_fuse_loader #(.FUSES(FUSES)) u_loader (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (cfg_shift),
        .bit_in   (cfg_bit),
        .fuses    (fuses),
        .done     (cfg_done)
    );

    pal_and_plane #(.NSIG(NSIG), .ROWS(ROWS)) u_plane (
        .fuses (fuses),
        .sig   (sig),
        .pt    (pt)
    );

    for (genvar k = 0; k < CELLS; k++) begin : g_cell
        if (k >= FIRST_REG && k < FIRST_REG + NREG) begin : g_reg
            pal_reg_cell #(.TERMS(TERMS)) u_reg (
                .clk      (clk),
                .rst_n    (rst_n),
                .loaded   (cfg_done),
                .pre_mode (pre_mode),
                .pre_lvl  (pre_lvl[k-FIRST_REG]),
                .terms    (pt[k*TERMS +: TERMS]),
                .state    (state[k-FIRST_REG])
            );
        end else begin : g_io
            localparam int J = (k < FIRST_REG) ? k : k - NREG;
            pal_io_cell #(.TERMS(TERMS)) u_io (
                .loaded (cfg_done),
                .terms  (pt[k*TERMS +: TERMS]),
                .out    (io_out[J]),
                .en     (io_oe[J])
            );
        end
    end

    assign q_out = ~state;
    assign q_en  = cfg_done & ~oe_n & ~pre_mode;
endmodule

// File: rtl/pal_array_chk.sv
// Temporal checks on the array's pins; attached to every top instance.
module pal_array_chk #(
    parameter int NREG = 4,
    parameter int NIO  = 4
) (
    input logic            clk,
    input logic            rst_n,
    input logic            cfg_done,
    input logic            oe_n,
    input logic            pre_mode,
    input logic [NREG-1:0] pre_lvl,
    input logic [NREG-1:0] q_out,
    input logic            q_en,
    input logic [NIO-1:0]  io_oe
);
    // R8: nothing drives before the map is loaded
    a_r8_off_until_loaded: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_done |-> (!q_en && io_oe == '0));

    // R8: registers hold while unloaded
    a_r8_hold_until_loaded: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_done |=> $stable(q_out));

    // R10: load completion is sticky
    a_r10_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_done |=> cfg_done);

    // R9: preload makes pins read the applied level
    a_r9_preload_level: assert property (@(posedge clk) disable iff (!rst_n)
        (pre_mode && cfg_done) |=> (q_out == $past(pre_lvl)));

    // R6: shared enable or preload turns registered pins off
    a_r6_pin_enable: assert property (@(posedge clk) disable iff (!rst_n)
        (oe_n || pre_mode) |-> !q_en);
endmodule

bind pal_array_top pal_array_chk #(.NREG(NREG), .NIO(NIO)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_done (cfg_done),
    .oe_n     (oe_n),
    .pre_mode (pre_mode),
    .pre_lvl  (pre_lvl),
    .q_out    (q_out),
    .q_en     (q_en),
    .io_oe    (io_oe)
);

// File: tb/tb_pal_array_top.sv
module tb_pal_array_top;
    localparam int NFUSE = 2560;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_shift = 1'b0, cfg_bit = 1'b0;
    logic        cfg_done;
    logic [11:0] din = '0;
    logic        oe_n = 1'b1, pre_mode = 1'b0;
    logic [3:0]  pre_lvl = '0, q_out, io_in = '0, io_out, io_oe;
    logic        q_en;

    int errors = 0, checks = 0;
    logic [NFUSE-1:0] fmap;
    // Reference model state.
    logic [3:0] mstate = '0;
    int         mcnt = 0;

    always #10 clk = ~clk;

    pal_array_top dut (
        .clk(clk), .rst_n(rst_n), .cfg_shift(cfg_shift), .cfg_bit(cfg_bit),
        .cfg_done(cfg_done), .din(din), .oe_n(oe_n), .pre_mode(pre_mode),
        .pre_lvl(pre_lvl), .q_out(q_out), .q_en(q_en), .io_in(io_in),
        .io_out(io_out), .io_oe(io_oe)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // Fuse map helpers: row made false, or literal added to a row.
    task automatic row_clear(input int r);
        for (int c = 0; c < 40; c++) fmap[40*r + c] = 1'b0;
    endtask
    task automatic row_false(input int r);
        row_clear(r);
        fmap[40*r] = 1'b1;
        fmap[40*r + 1] = 1'b1;
    endtask
    task automatic lit(input int r, input int s, input int neg);
        fmap[40*r + 2*s + neg] = 1'b1;
    endtask

    // Counter with din[0] as count enable; four distinct I/O functions.
    task automatic build_map();
        for (int r = 0; r < 64; r++) row_false(r);
        row_clear(0);  lit(0, 1, 0);                     // io0 enable = din1
        row_clear(1);  lit(1, 2, 0); lit(1, 3, 0);       // io0 = din2&din3
        row_clear(8);                                    // io1 enable always
        row_clear(9);  lit(9, 4, 0);                     // io1 |= din4
        row_clear(10); lit(10, 5, 1);                    // io1 |= ~din5
        row_clear(16); lit(16, 12, 1); lit(16, 0, 0);
        row_clear(17); lit(17, 12, 0); lit(17, 0, 1);
        row_clear(24); lit(24, 13, 0); lit(24, 12, 1); lit(24, 0, 0);
        row_clear(25); lit(25, 13, 1); lit(25, 12, 0); lit(25, 0, 0);
        row_clear(26); lit(26, 13, 0); lit(26, 0, 1);
        row_clear(32); lit(32, 14, 0); lit(32, 13, 1); lit(32, 0, 0);
        row_clear(33); lit(33, 14, 0); lit(33, 12, 1); lit(33, 0, 0);
        row_clear(34); lit(34, 14, 1); lit(34, 13, 0); lit(34, 12, 0); lit(34, 0, 0);
        row_clear(35); lit(35, 14, 0); lit(35, 0, 1);
        row_clear(40); lit(40, 15, 0); lit(40, 14, 1); lit(40, 0, 0);
        row_clear(41); lit(41, 15, 0); lit(41, 13, 1); lit(41, 0, 0);
        row_clear(42); lit(42, 15, 0); lit(42, 12, 1); lit(42, 0, 0);
        row_clear(43); lit(43, 15, 1); lit(43, 14, 0); lit(43, 13, 0);
        lit(43, 12, 0); lit(43, 0, 0);
        row_clear(44); lit(44, 15, 0); lit(44, 0, 1);
        row_clear(56); lit(56, 6, 0);                    // io3 enable = din6
        row_clear(57); lit(57, 18, 0);                   // io3 = io_in[2]
    endtask

    // Compare outputs, then advance the model across one rising edge.
    task automatic step();
        logic mdone;
        logic [3:0] eoe, eio;
        #1;
        mdone = (mcnt == NFUSE);
        eoe = mdone ? {din[6], 1'b0, 1'b1, din[1]} : 4'h0;
        eio = {io_in[2], 1'b0, din[4] | ~din[5], din[2] & din[3]};
        check(q_out === ~mstate, "R5/R6/R8/R9 q_out", q_out, ~mstate);
        check(q_en === (mdone & ~oe_n & ~pre_mode), "R6/R8 q_en", q_en,
              mdone & ~oe_n & ~pre_mode);
        check(io_oe === eoe, "R3/R4/R7/R8 io_oe", io_oe, eoe);
        if (mdone)
            check(io_out === eio, "R2/R3/R7/R11 io_out", io_out, eio);
        check(cfg_done === mdone, "R1/R10 cfg_done", cfg_done, mdone);
        @(posedge clk);
        if (!rst_n) begin
            mstate = '0;
            mcnt = 0;
        end else begin
            if (mdone) begin
                if (pre_mode) mstate = ~pre_lvl;
                else if (din[0]) mstate = mstate + 4'd1;
            end
            if (cfg_shift && mcnt < NFUSE) mcnt++;
        end
        @(negedge clk);
    endtask

    task automatic rand_inputs(input bit count_en);
        din = 12'($urandom);
        din[0] = count_en;
        io_in = 4'($urandom);
    endtask

    task automatic load_map();
        for (int i = 0; i < NFUSE; i++) begin
            cfg_shift = 1'b1;
            cfg_bit = fmap[i];
            oe_n = 1'($urandom);
            rand_inputs(1'b1);
            step();
        end
        cfg_shift = 1'b0;
    endtask

    initial begin
        #(20 * 190000);
        errors++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        build_map();
        @(negedge clk);
        // R8: reset state
        repeat (3) step();
        rst_n = 1'b1;
        oe_n = 1'b0;
        // R1: load and watch done rise exactly on the last bit (checked in step)
        load_map();
        // R5: count with enable, wrap past 15
        for (int i = 0; i < 40; i++) begin rand_inputs(1'b1); step(); end
        // R5: hold with enable low; R6: toggle oe_n
        for (int i = 0; i < 10; i++) begin
            rand_inputs(1'b0); oe_n = 1'(i % 2); step();
        end
        oe_n = 1'b0;
        // R9: preload an arbitrary state while counting would otherwise run
        pre_mode = 1'b1; pre_lvl = 4'b1010; rand_inputs(1'b1); step();
        pre_mode = 1'b0;
        for (int i = 0; i < 8; i++) begin rand_inputs(1'b1); step(); end
        // R10: shifts after done are ignored
        cfg_shift = 1'b1;
        for (int i = 0; i < 30; i++) begin cfg_bit = 1'($urandom); rand_inputs(1'b1); step(); end
        cfg_shift = 1'b0;
        // R8: reset mid-run clears registers and load progress
        rst_n = 1'b0; step(); step();
        rst_n = 1'b1;
        load_map();
        for (int i = 0; i < 20; i++) begin rand_inputs(1'($urandom)); step(); end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule